// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the fetch address for a program store of 2048 words, each 14 bits wide, and works out the next address every time an instruction is retired. Four 512-word pages make up the address space. Short jumps and short calls take their two page bits from a status register and the rest of the address from the instruction word. Long jumps and long calls carry a full 11-bit target. A direct write to the counter's low byte takes the byte from the ALU. Straight-line code advances by one word, or by two when a conditional skip is taken.

Return addresses go to a two-entry hardware stack. A call pushes the address of the word that follows it. A return, or a return that also hands back a literal, pops that address. The block recognises the control-transfer encodings in the instruction word itself. The surrounding core only signals an ALU write to the counter's low byte, a skip, and the page bits.

`ctl_valid` marks the cycle in which an instruction retires. The block accepts one retirement in every cycle, so it has no ready output and never applies back-pressure. When `ctl_valid` is low, the fetch address holds its value. The literal output is valid only in the cycle its qualifier is high. Nothing downstream can stall it, so it must be taken in that cycle.

Top module: `pc_sequencer`

## Requirements
- R1: When reset is released, the fetch address is 7FFh and both stack entries are 000h.
- R2: Long jump, instruction bits 13:11 = 101: the next address is instruction bits 10:0.
- R3: Short jump, instruction bits 13:9 = 11001: the next address is {page[1:0], instruction bits 8:0}. Page 00 selects 000h–1FFh, 01 selects 200h–3FFh, 10 selects 400h–5FFh and 11 selects 600h–7FFh.
- R4: Short call, instruction bits 13:8 = 110000: the next address is {page, 0, instruction bits 7:0}, so bit 8 is always zero. The current address plus one is pushed.
- R5: Long call, instruction bits 13:11 = 100: the next address is instruction bits 10:0, and the current address plus one is pushed.
- R6: Return, instruction = 01000000000100b: the next address is the newest stack entry, which is then popped.
- R7: Direct low-byte write (`pcl_wr` high with a non-transfer instruction): the next address is {page, 0, alu_byte}.
- R8: Any other retired instruction advances the address by one, wrapping from 7FFh to 000h.
- R9: A `skip` on a sequential instruction advances the address by two, modulo 2048.
- R10: Priority: the decoded transfer wins over `pcl_wr`, and `pcl_wr` wins over `skip`. `skip` and `pcl_wr` have no effect on a transfer instruction.
- R11: A push onto a full stack discards the oldest entry.
- R12: A pop from an empty stack returns the entry that was held last.
- R13: Return with literal, instruction bits 13:8 = 110001: acts as a return, and in that same cycle `lit_valid` is high and `lit_data` equals instruction bits 7:0.
- R14: While `ctl_valid` is low, the fetch address and the stack do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | An instruction retires this cycle |
| instr | input | 14 | Retiring instruction word |
| pcl_wr | input | 1 | ALU result targets the counter's low byte |
| alu_byte | input | 8 | ALU result byte |
| page | input | 2 | Status page-select bits |
| skip | input | 1 | Conditional skip taken |
| fetch_addr | output | 11 | Current fetch address |
| lit_valid | output | 1 | Return-with-literal retiring |
| lit_data | output | 8 | Literal bound for the working register |

## Verification
The bench builds the block with the default 11-bit address and a stack depth of two. At that size every long-jump target, every page and 9-bit short-jump offset, and every page and byte combination for short calls and low-byte writes can be swept in full. The small stack depth also means a short, hand-built sequence of calls and returns reaches the overflow case and the empty-pop case. Wrap-around at the top of the address space is exercised for both the plain increment and the skip.

// File: rtl/pc_seq_pkg.sv
`timescale 1ns/1ps
package pc_seq_pkg;

  typedef enum logic [2:0] {
    XF_SEQ    = 3'd0,
    XF_PCL    = 3'd1,
    XF_SJMP   = 3'd2,
    XF_SCALL  = 3'd3,
    XF_LJMP   = 3'd4,
    XF_LCALL  = 3'd5,
    XF_RET    = 3'd6,
    XF_RETLIT = 3'd7
  } xfer_e;

  localparam logic [2:0] OPC_LCALL  = 3'b100;
  localparam logic [2:0] OPC_LJMP   = 3'b101;
  localparam logic [4:0] OPC_SJMP   = 5'b11001;
  localparam logic [5:0] OPC_SCALL  = 6'b110000;
  localparam logic [5:0] OPC_RETLIT = 6'b110001;
  localparam logic [5:0] OPC_RETHI  = 6'b010000;
  localparam int         RET_LOW    = 4;

  localparam int BYTE_W  = 8;
  localparam int SHORT_W = 9;

endpackage

// File: rtl/pc_xfer_decode.sv
`timescale 1ns/1ps
module pc_xfer_decode
  import pc_seq_pkg::*;
#(
  parameter int IW = 14
) (
  input  logic [IW-1:0] instr,
  input  logic          pcl_wr,
  output xfer_e         xfer
);

  localparam int LOWF = IW - 6;

  logic is_lcall, is_ljmp, is_sjmp, is_scall, is_retlit, is_ret;

  always_comb begin
    is_lcall  = (instr[IW-1 -: 3] == OPC_LCALL);
    is_ljmp   = (instr[IW-1 -: 3] == OPC_LJMP);
    is_sjmp   = (instr[IW-1 -: 5] == OPC_SJMP);
    is_scall  = (instr[IW-1 -: 6] == OPC_SCALL);
    is_retlit = (instr[IW-1 -: 6] == OPC_RETLIT);
    is_ret    = (instr == {OPC_RETHI, LOWF'(RET_LOW)});
  end

  always_comb begin
    if (is_lcall)       xfer = XF_LCALL;
    else if (is_ljmp)   xfer = XF_LJMP;
    else if (is_sjmp)   xfer = XF_SJMP;
    else if (is_scall)  xfer = XF_SCALL;
    else if (is_retlit) xfer = XF_RETLIT;
    else if (is_ret)    xfer = XF_RET;
    else if (pcl_wr)    xfer = XF_PCL;
    else                xfer = XF_SEQ;
  end

endmodule

// File: rtl/pc_ret_stack.sv
`timescale 1ns/1ps
module pc_ret_stack #(
  parameter int AW    = 11,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] top
);

  logic [AW-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    logic [AW-1:0] from_above;
    logic [AW-1:0] from_below;

    if (g == 0) begin : g_head
      assign from_above = din;
    end else begin : g_body
      assign from_above = ent[g-1];
    end

    if (g == DEPTH - 1) begin : g_tail
      assign from_below = ent[g];
    end else begin : g_mid
      assign from_below = ent[g+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)    ent[g] <= '0;
      else if (push) ent[g] <= from_above;
      else if (pop)  ent[g] <= from_below;
    end
  end

  assign top = ent[0];

endmodule

// File: rtl/pc_target_mux.sv
`timescale 1ns/1ps
module pc_target_mux
  import pc_seq_pkg::*;
#(
  parameter int AW = 11
) (
  input  xfer_e                 xfer,
  input  logic [AW+2:0]         instr,
  input  logic [AW-SHORT_W-1:0] page,
  input  logic [BYTE_W-1:0]     alu_byte,
  input  logic                  skip,
  input  logic [AW-1:0]         pc,
  input  logic [AW-1:0]         stack_top,
  output logic [AW-1:0]         next_pc,
  output logic [AW-1:0]         link,
  output logic                  push,
  output logic                  pop
);

  localparam int PW = AW - SHORT_W;

  logic [AW-1:0] step;

  always_comb begin
    step = AW'(1) + (skip ? AW'(1) : AW'(0));
    link = pc + AW'(1);
  end

  always_comb begin
    push = 1'b0;
    pop  = 1'b0;
    unique case (xfer)
      XF_PCL:    next_pc = {page, 1'b0, alu_byte};
      XF_SJMP:   next_pc = {page, instr[SHORT_W-1:0]};
      XF_SCALL: begin
        next_pc = {page, 1'b0, instr[BYTE_W-1:0]};
        push    = 1'b1;
      end
      XF_LJMP:   next_pc = instr[AW-1:0];
      XF_LCALL: begin
        next_pc = instr[AW-1:0];
        push    = 1'b1;
      end
      XF_RET, XF_RETLIT: begin
        next_pc = stack_top;
        pop     = 1'b1;
      end
      default:   next_pc = pc + step;
    endcase
  end

  logic unused_pw;
  assign unused_pw = ^{PW{1'b0}};

endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int AW    = 11,
  parameter int DEPTH = 2,
  localparam int IW   = AW + 3,
  localparam int PW   = AW - SHORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_valid,
  input  logic [IW-1:0]     instr,
  input  logic              pcl_wr,
  input  logic [BYTE_W-1:0] alu_byte,
  input  logic [PW-1:0]     page,
  input  logic              skip,
  output logic [AW-1:0]     fetch_addr,
  output logic              lit_valid,
  output logic [BYTE_W-1:0] lit_data
);

  localparam logic [AW-1:0] RESET_VEC = '1;

  xfer_e         xfer;
  logic [AW-1:0] pc_q, next_pc, link, stack_top;
  logic          push_raw, pop_raw;

  pc_xfer_decode #(.IW(IW)) u_dec (
    .instr  (instr),
    .pcl_wr (pcl_wr),
    .xfer   (xfer)
  );

  pc_target_mux #(.AW(AW)) u_mux (
    .xfer      (xfer),
    .instr     (instr),
    .page      (page),
    .alu_byte  (alu_byte),
    .skip      (skip),
    .pc        (pc_q),
    .stack_top (stack_top),
    .next_pc   (next_pc),
    .link      (link),
    .push      (push_raw),
    .pop       (pop_raw)
  );

  pc_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ctl_valid && push_raw),
    .pop   (ctl_valid && pop_raw),
    .din   (link),
    .top   (stack_top)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         pc_q <= RESET_VEC;
    else if (ctl_valid) pc_q <= next_pc;
  end

  assign fetch_addr = pc_q;
  assign lit_valid  = ctl_valid && (xfer == XF_RETLIT);
  assign lit_data   = instr[BYTE_W-1:0];

endmodule

// File: rtl/pc_sequencer_chk.sv
`timescale 1ns/1ps
module pc_sequencer_chk #(
  parameter int AW = 11,
  localparam int IW = AW + 3,
  localparam int PW = AW - 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_valid,
  input logic [IW-1:0] instr,
  input logic          pcl_wr,
  input logic [7:0]    alu_byte,
  input logic [PW-1:0] page,
  input logic          skip,
  input logic [AW-1:0] fetch_addr,
  input logic          lit_valid
);

  logic plain;
  assign plain = (instr[IW-1] == 1'b0) &&
                 (instr != {6'b010000, (IW-6)'(4)});

  // R14
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_valid |=> $stable(fetch_addr));

  // R2
  long_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && instr[IW-1 -: 3] == 3'b101 |=> fetch_addr == $past(instr[AW-1:0]));

  // R5
  long_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && instr[IW-1 -: 3] == 3'b100 |=> fetch_addr == $past(instr[AW-1:0]));

  // R3
  short_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && instr[IW-1 -: 5] == 5'b11001 |=>
      fetch_addr == {$past(page), $past(instr[8:0])});

  // R4
  short_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && instr[IW-1 -: 6] == 6'b110000 |=>
      fetch_addr[8] == 1'b0 && fetch_addr[AW-1:9] == $past(page));

  // R7
  low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && plain && pcl_wr |=>
      fetch_addr == {$past(page), 1'b0, $past(alu_byte)});

  // R8
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && plain && !pcl_wr && !skip |=>
      fetch_addr == AW'($past(fetch_addr) + AW'(1)));

  // R9
  skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && plain && !pcl_wr && skip |=>
      fetch_addr == AW'($past(fetch_addr) + AW'(2)));

  // R13
  literal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lit_valid |-> ctl_valid && instr[IW-1 -: 6] == 6'b110001);

endmodule

bind pc_sequencer pc_sequencer_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_valid  (ctl_valid),
  .instr      (instr),
  .pcl_wr     (pcl_wr),
  .alu_byte   (alu_byte),
  .page       (page),
  .skip       (skip),
  .fetch_addr (fetch_addr),
  .lit_valid  (lit_valid)
);

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_valid = 1'b0;
  logic [13:0] instr = '0;
  logic        pcl_wr = 1'b0;
  logic [7:0]  alu_byte = '0;
  logic [1:0]  page = '0;
  logic        skip = 1'b0;
  logic [10:0] fetch_addr;
  logic        lit_valid;
  logic [7:0]  lit_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [10:0] m_pc, m_s0, m_s1;

  localparam logic [13:0] W_RET  = 14'b010000_00000100;
  localparam logic [13:0] W_NOP  = 14'b011000_00000000;

  always #2.5 clk = ~clk;

  pc_sequencer i_pc_sequencer (
    .clk, .rst_n, .ctl_valid, .instr, .pcl_wr, .alu_byte,
    .page, .skip, .fetch_addr, .lit_valid, .lit_data
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Retire one instruction; update the reference state from the requirements.
  task automatic run(input logic [13:0] w, input logic pw, input logic sk,
                     input logic [7:0] ab, input logic [1:0] pg);
    logic [10:0] nx;
    instr = w; pcl_wr = pw; skip = sk; alu_byte = ab; page = pg;
    ctl_valid = 1'b1;
    if (w[13:11] == 3'b100) begin
      nx = w[10:0]; m_s1 = m_s0; m_s0 = m_pc + 11'd1;
    end else if (w[13:11] == 3'b101) nx = w[10:0];
    else if (w[13:9] == 5'b11001) nx = {pg, w[8:0]};
    else if (w[13:8] == 6'b110000) begin
      nx = {pg, 1'b0, w[7:0]}; m_s1 = m_s0; m_s0 = m_pc + 11'd1;
    end else if (w[13:8] == 6'b110001 || w == W_RET) begin
      nx = m_s0; m_s0 = m_s1;
    end else if (pw) nx = {pg, 1'b0, ab};
    else nx = m_pc + (sk ? 11'd2 : 11'd1);
    m_pc = nx;
    @(posedge clk); #1;
    ctl_valid = 1'b0; pcl_wr = 1'b0; skip = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    m_pc = 11'h7FF; m_s0 = '0; m_s1 = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R1: reset vector
    chk("R1", fetch_addr, 11'h7FF);
    // R14: no retirement, no change
    repeat (3) @(posedge clk); #1;
    chk("R14", fetch_addr, 11'h7FF);
    // R1: empty stack returns zero after reset
    run(W_RET, 0, 0, 0, 0);
    chk("R1", fetch_addr, 11'h000);

    // R2: every long-jump target
    for (int a = 0; a < 2048; a++) begin
      run({3'b101, 11'(a)}, 0, 0, 0, 0);
      chk("R2", fetch_addr, a);
    end

    // R3: every page and short offset
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 512; a++) begin
        run({5'b11001, 9'(a)}, 0, 0, 0, 2'(p));
        chk("R3", fetch_addr, p * 512 + a);
      end

    // R4/R6: short call to every page and byte, then return
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 256; a++) begin
        run({3'b101, 11'h3A5}, 0, 0, 0, 0);
        run({6'b110000, 8'(a)}, 0, 0, 0, 2'(p));
        chk("R4", fetch_addr, p * 512 + a);
        run(W_RET, 0, 0, 0, 0);
        chk("R6", fetch_addr, 11'h3A6);
      end

    // R5: long calls over a spread of targets, with return
    for (int a = 0; a < 2048; a += 7) begin
      run({3'b101, 11'h0F0}, 0, 0, 0, 0);
      run({3'b100, 11'(a)}, 0, 0, 0, 0);
      chk("R5", fetch_addr, a);
      run(W_RET, 0, 0, 0, 0);
      chk("R6", fetch_addr, 11'h0F1);
    end

    // R7: direct low-byte write, all pages and bytes
    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 256; b++) begin
        run(W_NOP, 1, 0, 8'(b), 2'(p));
        chk("R7", fetch_addr, p * 512 + b);
      end

    // R8: increment with wrap
    run({3'b101, 11'h7FE}, 0, 0, 0, 0);
    run(W_NOP, 0, 0, 0, 0);
    chk("R8", fetch_addr, 11'h7FF);
    run(W_NOP, 0, 0, 0, 0);
    chk("R8", fetch_addr, 11'h000);
    // R9: skip adds two, including the wrap points
    for (int s = 2040; s < 2048; s++) begin
      run({3'b101, 11'(s)}, 0, 0, 0, 0);
      run(W_NOP, 0, 1, 0, 0);
      chk("R9", fetch_addr, (s + 2) % 2048);
    end

    // R10: transfers ignore skip and pcl_wr; pcl_wr beats skip
    run({3'b101, 11'h155}, 1, 1, 8'hEE, 2'd3);
    chk("R10", fetch_addr, 11'h155);
    run({5'b11001, 9'h0AA}, 1, 1, 8'hEE, 2'd1);
    chk("R10", fetch_addr, 11'h2AA);
    run(W_NOP, 1, 1, 8'h31, 2'd2);
    chk("R10", fetch_addr, 11'h431);

    // R6: nested calls unwind in order
    run({3'b101, 11'h123}, 0, 0, 0, 0);
    run({3'b100, 11'h400}, 0, 0, 0, 0);
    run({6'b110000, 8'h55}, 0, 0, 0, 2'd2);
    chk("R4", fetch_addr, 11'h455);
    run(W_RET, 0, 0, 0, 0);
    chk("R6", fetch_addr, 11'h401);
    run(W_RET, 0, 0, 0, 0);
    chk("R6", fetch_addr, 11'h124);

    // R11/R12: overflow drops the oldest; empty pops repeat the last entry
    run({3'b100, 11'h200}, 0, 0, 0, 0);
    run({3'b100, 11'h300}, 0, 0, 0, 0);
    run({3'b100, 11'h600}, 0, 0, 0, 0);
    run(W_RET, 0, 0, 0, 0);
    chk("R11", fetch_addr, 11'h301);
    run(W_RET, 0, 0, 0, 0);
    chk("R11", fetch_addr, 11'h201);
    run(W_RET, 0, 0, 0, 0);
    chk("R12", fetch_addr, 11'h201);
    run(W_RET, 0, 0, 0, 0);
    chk("R12", fetch_addr, 11'h201);

    // R13: return with literal
    run({3'b101, 11'h0C0}, 0, 0, 0, 0);
    run({3'b100, 11'h5A0}, 0, 0, 0, 0);
    instr = {6'b110001, 8'h9C}; #1;
    chk("R13", lit_valid, 0);
    run({6'b110001, 8'h9C}, 0, 0, 0, 0);
    chk("R13", fetch_addr, 11'h0C1);
    ctl_valid = 1'b1; instr = {6'b110001, 8'h3D}; #1;
    chk("R13", lit_valid, 1);
    chk("R13", lit_data, 8'h3D);
    ctl_valid = 1'b0; instr = W_NOP; #1;
    chk("R13", lit_valid, 0);

    // R14: idle with transfer word present leaves state alone
    instr = {3'b101, 11'h777}; page = 2'd3;
    repeat (4) @(posedge clk); #1;
    chk("R14", fetch_addr, m_pc);
    run(W_RET, 0, 0, 0, 0);
    chk("R14", fetch_addr, m_pc);

    summary();
  end

endmodule